// File: doc/BRIEF.md
# SATA Host Command Sequencer

This block is the control path of a SATA host application layer. A user hands it one command at a time: a two-bit opcode, a 48-bit start sector and a 48-bit sector count. It builds the host-to-device register FIS for that command and sends it to the transport layer. It then follows the FIS exchange with the device until the command completes or fails. Write and read requests larger than 65536 sectors are cut into a series of extended DMA commands, each starting where the previous one stopped.

Every received FIS type is compared with the types the current state allows. While the sequencer waits on identify, write or read traffic, a cycle counter enforces a limit on how long the device may stay silent. Any fault sets one bit of a sticky error vector and parks the sequencer in a halt state with busy held high; only reset leaves it. The data payload path is not part of this block. It learns from a one-cycle pulse when the device has activated DMA, and on identify completion it supplies the capacity word that the sequencer latches.

States: `ST_INIT` (wait for the device signature), `ST_IDLE`, `ST_SEND` (emit the five-dword command FIS), `ST_ID_PIO` and `ST_ID_DATA` (identify), `ST_ERASE_WAIT`, `ST_WR_WAIT`, `ST_RD_WAIT` and `ST_HALT`. Transitions:
- `INIT→IDLE`: on a device-to-host register FIS.
- `IDLE→SEND`: on an accepted request.
- `SEND→` the opcode's wait state: on the final beat.
- `ID_PIO→ID_DATA`: on PIO setup.
- `ID_DATA→IDLE`: on the data FIS.
- `ERASE_WAIT→IDLE`: on a clean register FIS.
- `WR_WAIT`/`RD_WAIT→SEND`: on a clean register FIS while sectors remain.
- `WR_WAIT`/`RD_WAIT→IDLE`: on a clean register FIS when none remain.
- any state `→HALT`: on an error.

Top module: `sata_cmd_seq`

## Requirements
- R1: Opcode 00 sends ATA command byte 0xEC (identify), 01 sends 0xF4 (security erase), 10 sends 0x35 (write DMA ext) and 11 sends 0x25 (read DMA ext).
- R2: After reset, busy is high and stays high until a received FIS of type 0x34 arrives. Requests and other FIS types before it are ignored, and no FIS is sent.
- R3: A request is accepted only while busy is low, and busy is high in the cycle after acceptance. A request made while busy is ignored and sends nothing.
- R4: The command FIS is five 32-bit beats, in this order:
  - dw0 = {0x00, command byte, 0x80, 0x27}
  - dw1 = {0x40, sector[23:0]}
  - dw2 = {0x00, sector[47:24]}
  - dw3 = {0x0000, count}
  - dw4 = 0

  tx_last marks dw4, and tx_data holds steady while tx_ready is low.
- R5: Identify and erase ignore the address and length inputs: their sector and count fields are zero.
- R6: A write or read of L sectors from address A issues commands of min(remaining, 65536) sectors, each start address advanced by the previous size. A size of 65536 is encoded as count 0. Busy drops after the register FIS that ends the last command.
- R7: In a write, each DMA-activate FIS (0x39) yields one one-cycle pulse on wr_data_go. In a read, any number of data FISes (0x46) are accepted. In both, a 0x34 with its error bit clear ends the command in progress.
- R8: Identify expects PIO setup (0x5F), then data (0x46), and then returns to idle. The capacity output is zero after reset, takes iden_capacity only when identify completes, and holds at all other times.
- R9: Error bits:
  - bit 0: rx_link_err.
  - bit 1: a data FIS where none is expected.
  - bit 2: a 0x34 or 0x5F with its error bit set, or any other unexpected type during read, erase, idle or send.
  - bit 3: an unexpected non-data type during a write.
  - bit 4: an unexpected non-data type during identify.
- R10: In the identify, write and read wait states, bit 5 is set once timeout_limit cycles pass with no received FIS. Every received FIS restarts the count, and a limit of 0 disables the check.
- R11: While an erase is waiting for the device, no timeout is raised however long it waits.
- R12: Any error bit moves the block to halt: busy stays high, requests are ignored, err_flag is the OR of the vector, bits 31:6 read zero, and only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_req | input | 1 | Command request |
| cmd_op | input | 2 | Opcode (R1) |
| cmd_addr | input | 48 | Start sector |
| cmd_len | input | 48 | Sector count |
| busy | output | 1 | Not ready for a request |
| capacity | output | 48 | Device capacity in sectors |
| err_flag | output | 1 | Any error bit set |
| err_vec | output | 32 | Sticky error vector |
| timeout_limit | input | 32 | FIS wait limit in cycles, 0 disables |
| iden_capacity | input | 48 | Capacity from the identify data path |
| tx_valid | output | 1 | Command FIS beat valid |
| tx_ready | input | 1 | Transport accepts beat |
| tx_data | output | 32 | Command FIS beat |
| tx_last | output | 1 | Final beat |
| rx_fis_valid | input | 1 | One-cycle strobe of a received FIS header |
| rx_fis_type | input | 8 | Received FIS type |
| rx_fis_err | input | 1 | Error bit of the received status field |
| rx_link_err | input | 1 | Lower-layer error strobe |
| wr_data_go | output | 1 | Pulse: send one write data FIS |

## Verification
Chunking is probed at lengths of exactly 65536, just above a multiple of it, and a single sector. A design with an off-by-one chunk limit, a wrong count encoding or a stale start address would emit a command FIS with the wrong fields or one command too many. The timeout is checked three ways: a read whose FISes arrive more often than the limit must not fail, an idle read must fail with bit 5, and a long erase must not fail; a counter that never restarts or ignores the erase exemption trips these. Each error class is provoked after its own reset, so a wrong bit position, a lost stickiness or a halt that still accepts requests shows up as a changed vector or a stray command FIS.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int LBA_W = 48;
    localparam int CNT_W = 16;
    localparam int ERR_BITS = 6;

    typedef enum logic [1:0] {
        OP_IDENTIFY = 2'b00,
        OP_ERASE    = 2'b01,
        OP_WRITE    = 2'b10,
        OP_READ     = 2'b11
    } op_t;

    typedef enum logic [3:0] {
        ST_INIT,
        ST_IDLE,
        ST_SEND,
        ST_ID_PIO,
        ST_ID_DATA,
        ST_ERASE_WAIT,
        ST_WR_WAIT,
        ST_RD_WAIT,
        ST_HALT
    } state_t;

    localparam logic [7:0] FIS_H2D       = 8'h27;
    localparam logic [7:0] FIS_D2H       = 8'h34;
    localparam logic [7:0] FIS_DMA_ACT   = 8'h39;
    localparam logic [7:0] FIS_PIO_SETUP = 8'h5F;
    localparam logic [7:0] FIS_DATA      = 8'h46;

    localparam int E_LINK    = 0;
    localparam int E_DATA    = 1;
    localparam int E_STATUS  = 2;
    localparam int E_DMA     = 3;
    localparam int E_PIO     = 4;
    localparam int E_TIMEOUT = 5;

    function automatic logic [7:0] ata_opcode(op_t op);
        logic [7:0] r;
        unique case (op)
            OP_IDENTIFY: r = 8'hEC;
            OP_ERASE:    r = 8'hF4;
            OP_WRITE:    r = 8'h35;
            OP_READ:     r = 8'h25;
        endcase
        return r;
    endfunction

    // error bit for a FIS type not allowed while running op
    function automatic logic [ERR_BITS-1:0] unexpected_mask(op_t op, logic [7:0] ftype);
        logic [ERR_BITS-1:0] m;
        m = '0;
        if (ftype == FIS_DATA) begin
            m[E_DATA] = 1'b1;
        end else begin
            unique case (op)
                OP_IDENTIFY: m[E_PIO]    = 1'b1;
                OP_WRITE:    m[E_DMA]    = 1'b1;
                OP_ERASE,
                OP_READ:     m[E_STATUS] = 1'b1;
            endcase
        end
        return m;
    endfunction
endpackage

// File: rtl/seq_chunker.sv
module seq_chunker
    import seq_pkg::*;
#(
    parameter int CHUNK_LOG2 = CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic [LBA_W-1:0] addr_in,
    input  logic [LBA_W-1:0] len_in,
    output logic [LBA_W-1:0] cur_addr,
    output logic [CNT_W-1:0] chunk_cnt,
    output logic             last_chunk
);
    localparam logic [LBA_W-1:0] CHUNK = LBA_W'(1) << CHUNK_LOG2;

    logic [LBA_W-1:0] remaining;
    logic [LBA_W-1:0] chunk_len;

    always_comb begin
        chunk_len  = (remaining > CHUNK) ? CHUNK : remaining;
        last_chunk = (remaining <= CHUNK);
        chunk_cnt  = chunk_len[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            remaining <= '0;
        end else if (load) begin
            cur_addr  <= addr_in;
            remaining <= len_in;
        end else if (advance) begin
            cur_addr  <= cur_addr + chunk_len;
            remaining <= remaining - chunk_len;
        end
    end
endmodule

// File: rtl/seq_fis_tx.sv
module seq_fis_tx
    import seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             tx_ready,
    input  op_t              op,
    input  logic [LBA_W-1:0] lba,
    input  logic [CNT_W-1:0] count,
    output logic             tx_valid,
    output logic [31:0]      tx_data,
    output logic             tx_last,
    output logic             done
);
    localparam int NDW = 5;
    localparam int BW  = $clog2(NDW);

    logic [BW-1:0]    beat;
    logic             fire;
    logic             is_dma;
    logic [LBA_W-1:0] lba_f;
    logic [CNT_W-1:0] cnt_f;

    assign tx_valid = active;
    assign fire     = tx_valid & tx_ready;
    assign tx_last  = (beat == BW'(NDW - 1));
    assign done     = fire & tx_last;

    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            beat <= '0;
        end else if (fire) begin
            beat <= tx_last ? '0 : beat + 1'b1;
        end
    end

    always_comb begin
        is_dma = (op == OP_WRITE) || (op == OP_READ);
        lba_f  = is_dma ? lba : '0;
        cnt_f  = is_dma ? count : '0;
        unique case (beat)
            BW'(0):  tx_data = {8'h00, ata_opcode(op), 8'h80, FIS_H2D};
            BW'(1):  tx_data = {8'h40, lba_f[23:0]};
            BW'(2):  tx_data = {8'h00, lba_f[47:24]};
            BW'(3):  tx_data = {16'h0000, cnt_f};
            default: tx_data = 32'h0;
        endcase
    end
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) begin
            cnt <= '0;
        end else if (cnt != {W{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && !restart && (limit != '0) && (cnt >= limit);
endmodule

// File: rtl/sata_cmd_seq.sv
module sata_cmd_seq
    import seq_pkg::*;
#(
    parameter int TMO_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_req,
    input  logic [1:0]       cmd_op,
    input  logic [LBA_W-1:0] cmd_addr,
    input  logic [LBA_W-1:0] cmd_len,
    output logic             busy,
    output logic [LBA_W-1:0] capacity,
    output logic             err_flag,
    output logic [31:0]      err_vec,
    input  logic [TMO_W-1:0] timeout_limit,
    input  logic [LBA_W-1:0] iden_capacity,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [31:0]      tx_data,
    output logic             tx_last,
    input  logic             rx_fis_valid,
    input  logic [7:0]       rx_fis_type,
    input  logic             rx_fis_err,
    input  logic             rx_link_err,
    output logic             wr_data_go
);
    state_t              state, state_n;
    op_t                 op_q;
    logic [ERR_BITS-1:0] err_q, err_set;
    logic                accept, chunk_adv, cap_load, go_n;
    logic                tx_done, tmo_hit, tmo_run;
    logic [LBA_W-1:0]    cur_addr;
    logic [CNT_W-1:0]    chunk_cnt;
    logic                last_chunk;

    seq_chunker u_chunk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .advance   (chunk_adv),
        .addr_in   (cmd_addr),
        .len_in    (cmd_len),
        .cur_addr  (cur_addr),
        .chunk_cnt (chunk_cnt),
        .last_chunk(last_chunk)
    );

    seq_fis_tx u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (state == ST_SEND),
        .tx_ready(tx_ready),
        .op      (op_q),
        .lba     (cur_addr),
        .count   (chunk_cnt),
        .tx_valid(tx_valid),
        .tx_data (tx_data),
        .tx_last (tx_last),
        .done    (tx_done)
    );

    assign tmo_run = (state == ST_ID_PIO) || (state == ST_ID_DATA) ||
                     (state == ST_WR_WAIT) || (state == ST_RD_WAIT);

    seq_timer #(.W(TMO_W)) u_tmo (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmo_run),
        .restart(rx_fis_valid),
        .limit  (timeout_limit),
        .expired(tmo_hit)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_INIT;
        else        state <= state_n;
    end

    // next state and per-cycle events
    always_comb begin
        state_n   = state;
        err_set   = '0;
        accept    = 1'b0;
        chunk_adv = 1'b0;
        cap_load  = 1'b0;
        go_n      = 1'b0;
        if (rx_link_err && state != ST_HALT) begin
            err_set[E_LINK] = 1'b1;
        end else begin
            unique case (state)
                ST_INIT: begin
                    if (rx_fis_valid && rx_fis_type == FIS_D2H) state_n = ST_IDLE;
                end
                ST_IDLE: begin
                    if (rx_fis_valid) begin
                        if (rx_fis_type == FIS_DATA) err_set[E_DATA]   = 1'b1;
                        else                         err_set[E_STATUS] = 1'b1;
                    end else if (cmd_req) begin
                        accept  = 1'b1;
                        state_n = ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (rx_fis_valid) begin
                        err_set = unexpected_mask(op_q, rx_fis_type);
                    end else if (tx_done) begin
                        unique case (op_q)
                            OP_IDENTIFY: state_n = ST_ID_PIO;
                            OP_ERASE:    state_n = ST_ERASE_WAIT;
                            OP_WRITE:    state_n = ST_WR_WAIT;
                            OP_READ:     state_n = ST_RD_WAIT;
                        endcase
                    end
                end
                ST_ID_PIO: begin
                    if (rx_fis_valid) begin
                        if (rx_fis_type != FIS_PIO_SETUP) err_set = unexpected_mask(op_q, rx_fis_type);
                        else if (rx_fis_err)              err_set[E_STATUS] = 1'b1;
                        else                              state_n = ST_ID_DATA;
                    end else if (tmo_hit) begin
                        err_set[E_TIMEOUT] = 1'b1;
                    end
                end
                ST_ID_DATA: begin
                    if (rx_fis_valid) begin
                        if (rx_fis_type == FIS_DATA) begin
                            cap_load = 1'b1;
                            state_n  = ST_IDLE;
                        end else begin
                            err_set = unexpected_mask(op_q, rx_fis_type);
                        end
                    end else if (tmo_hit) begin
                        err_set[E_TIMEOUT] = 1'b1;
                    end
                end
                ST_ERASE_WAIT: begin
                    if (rx_fis_valid) begin
                        if (rx_fis_type != FIS_D2H) err_set = unexpected_mask(op_q, rx_fis_type);
                        else if (rx_fis_err)        err_set[E_STATUS] = 1'b1;
                        else                        state_n = ST_IDLE;
                    end
                end
                ST_WR_WAIT, ST_RD_WAIT: begin
                    if (rx_fis_valid) begin
                        if (state == ST_WR_WAIT && rx_fis_type == FIS_DMA_ACT) begin
                            go_n = 1'b1;
                        end else if (state == ST_RD_WAIT && rx_fis_type == FIS_DATA) begin
                            state_n = state;
                        end else if (rx_fis_type != FIS_D2H) begin
                            err_set = unexpected_mask(op_q, rx_fis_type);
                        end else if (rx_fis_err) begin
                            err_set[E_STATUS] = 1'b1;
                        end else if (last_chunk) begin
                            state_n = ST_IDLE;
                        end else begin
                            chunk_adv = 1'b1;
                            state_n   = ST_SEND;
                        end
                    end else if (tmo_hit) begin
                        err_set[E_TIMEOUT] = 1'b1;
                    end
                end
                default: state_n = ST_HALT;
            endcase
        end
        if (err_set != '0) state_n = ST_HALT;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q       <= OP_IDENTIFY;
            err_q      <= '0;
            capacity   <= '0;
            wr_data_go <= 1'b0;
        end else begin
            if (accept)   op_q     <= op_t'(cmd_op);
            if (cap_load) capacity <= iden_capacity;
            err_q      <= err_q | err_set;
            wr_data_go <= go_n;
        end
    end

    assign busy     = (state != ST_IDLE);
    assign err_vec  = {{(32 - ERR_BITS){1'b0}}, err_q};
    assign err_flag = |err_q;
endmodule

// File: rtl/sata_cmd_seq_chk.sv
module sata_cmd_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        cmd_req,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [31:0] tx_data,
    input logic        err_flag,
    input logic [31:0] err_vec,
    input logic [47:0] capacity,
    input logic        wr_data_go
);
    // R3
    busy_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_req) |=> busy);
    // R4
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
    // R3
    tx_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> busy);
    // R8
    capacity_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(capacity));
    // R12
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vec & $past(err_vec)) == $past(err_vec));
    // R12
    err_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> (busy && !tx_valid));
    // R7
    go_in_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data_go |-> busy);
endmodule

bind sata_cmd_seq sata_cmd_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .cmd_req   (cmd_req),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .err_flag  (err_flag),
    .err_vec   (err_vec),
    .capacity  (capacity),
    .wr_data_go(wr_data_go)
);

// File: tb/sata_cmd_seq_bench.sv
`timescale 1ns/1ps
module sata_cmd_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_req = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [47:0] cmd_addr = '0;
    logic [47:0] cmd_len = '0;
    logic        busy;
    logic [47:0] capacity;
    logic        err_flag;
    logic [31:0] err_vec;
    logic [31:0] timeout_limit = 32'd1000;
    logic [47:0] iden_capacity = '0;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic [31:0] tx_data;
    logic        tx_last;
    logic        rx_fis_valid = 1'b0;
    logic [7:0]  rx_fis_type = '0;
    logic        rx_fis_err = 1'b0;
    logic        rx_link_err = 1'b0;
    logic        wr_data_go;

    sata_cmd_seq u_sata_cmd_seq (
        .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .busy(busy), .capacity(capacity),
        .err_flag(err_flag), .err_vec(err_vec), .timeout_limit(timeout_limit),
        .iden_capacity(iden_capacity), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_last(tx_last), .rx_fis_valid(rx_fis_valid),
        .rx_fis_type(rx_fis_type), .rx_fis_err(rx_fis_err),
        .rx_link_err(rx_link_err), .wr_data_go(wr_data_go)
    );

    always #4 clk = ~clk;

    int nchk = 0;
    int nfail = 0;
    int ncap = 0;
    int ngo = 0;
    int cycles = 0;
    logic [31:0] cap_dw [16];
    logic        cap_last [16];
    logic        stall_en = 1'b0;

    // collector, away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_valid && tx_ready) begin
                if (ncap < 16) begin
                    cap_dw[ncap]   = tx_data;
                    cap_last[ncap] = tx_last;
                end
                ncap++;
            end
            if (wr_data_go) ngo++;
        end
    end

    always @(posedge clk) begin
        #1;
        tx_ready = stall_en ? (($urandom % 4) != 0) : 1'b1;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 150000) begin
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
            nfail++;
            nchk++;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_dw(input logic [1:0] op, input logic [47:0] a,
                                          input logic [15:0] c, input int i);
        logic [7:0]  cb;
        logic [47:0] aa;
        logic [15:0] cc;
        case (op)
            2'b00:   cb = 8'hEC;
            2'b01:   cb = 8'hF4;
            2'b10:   cb = 8'h35;
            default: cb = 8'h25;
        endcase
        aa = op[1] ? a : 48'h0;
        cc = op[1] ? c : 16'h0;
        case (i)
            0:       return {8'h00, cb, 8'h80, 8'h27};
            1:       return {8'h40, aa[23:0]};
            2:       return {8'h00, aa[47:24]};
            3:       return {16'h0, cc};
            default: return 32'h0;
        endcase
    endfunction

    task automatic send_rx(input logic [7:0] t, input logic e);
        rx_fis_valid = 1'b1;
        rx_fis_type  = t;
        rx_fis_err   = e;
        tick();
        rx_fis_valid = 1'b0;
        rx_fis_err   = 1'b0;
    endtask

    task automatic issue(input logic [1:0] op, input logic [47:0] a, input logic [47:0] l);
        ncap = 0;
        ngo  = 0;
        cmd_op = op; cmd_addr = a; cmd_len = l; cmd_req = 1'b1;
        tick();
        cmd_req = 1'b0;
    endtask

    task automatic wait_check_fis(input string tag, input logic [1:0] op,
                                  input logic [47:0] a, input logic [15:0] c);
        logic ok;
        for (int n = 0; n < 2000 && ncap < 5; n++) tick();
        ok = (ncap == 5);
        for (int i = 0; i < 5; i++)
            if (cap_dw[i] !== exp_dw(op, a, c, i) || cap_last[i] !== (i == 4)) ok = 1'b0;
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: fis n=%0d dw0=%h dw1=%h dw2=%h dw3=%h expected dw0=%h dw1=%h dw2=%h dw3=%h",
                     tag, ncap, cap_dw[0], cap_dw[1], cap_dw[2], cap_dw[3],
                     exp_dw(op, a, c, 0), exp_dw(op, a, c, 1), exp_dw(op, a, c, 2), exp_dw(op, a, c, 3));
        end
        ncap = 0;
    endtask

    task automatic reset_dut();
        rst_n = 1'b0;
        cmd_req = 1'b0;
        rx_fis_valid = 1'b0;
        rx_link_err = 1'b0;
        timeout_limit = 32'd1000;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R2 busy after reset", busy, 1);
        chk("R12 err after reset", {err_flag, err_vec}, 0);
        chk("R8 capacity after reset", capacity, 0);
        send_rx(8'h34, 1'b0);
        chk("R2 ready after signature", busy, 0);
    endtask

    // write/read over all chunks; poke makes a request while busy
    task automatic run_dma(input logic [1:0] op, input logic [47:0] a0,
                           input logic [47:0] len, input bit poke);
        logic [47:0] rem, a, c;
        int k;
        issue(op, a0, len);
        chk("R3 busy after accept", busy, 1);
        rem = len;
        a = a0;
        while (rem != 0) begin
            c = (rem > 48'd65536) ? 48'd65536 : rem;
            wait_check_fis("R6 chunk fis", op, a, c[15:0]);
            if (poke) begin
                cmd_op = ~op; cmd_req = 1'b1;
                tick();
                cmd_req = 1'b0;
                repeat (5) tick();
                chk("R3 request while busy ignored", ncap, 0);
                poke = 0;
            end
            k = 1 + ($urandom % 3);
            ngo = 0;
            for (int i = 0; i < k; i++) send_rx(op == 2'b10 ? 8'h39 : 8'h46, 1'b0);
            tick();
            if (op == 2'b10) chk("R7 write go pulses", ngo, k);
            chk("R7 no error in data phase", err_vec, 0);
            send_rx(8'h34, 1'b0);
            rem = rem - c;
            a = a + c;
            if (rem != 0) chk("R6 busy between chunks", busy, 1);
        end
        chk("R6 idle after last chunk", busy, 0);
        repeat (3) tick();
        chk("R6 no extra command", ncap, 0);
    endtask

    initial begin
        logic [47:0] ra, rl;
        logic [47:0] capv;
        void'($urandom(32'd4242));

        // R2: before signature, requests and other FIS types are ignored
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R2 reset busy", busy, 1);
        chk("R2 reset tx idle", tx_valid, 0);
        issue(2'b11, 48'h10, 48'h5);
        send_rx(8'h46, 1'b0);
        repeat (4) tick();
        chk("R2 no fis before signature", ncap, 0);
        chk("R2 still busy before signature", busy, 1);
        reset_dut();

        // identify: address/length ignored, capacity latched
        capv = 48'h0001_D1C0_BEEF;
        iden_capacity = capv;
        issue(2'b00, 48'h1234_5678_9ABC, 48'h55);
        wait_check_fis("R1 R5 identify fis", 2'b00, 48'h0, 16'h0);
        chk("R8 capacity before completion", capacity, 0);
        send_rx(8'h5F, 1'b0);
        chk("R8 busy after pio setup", busy, 1);
        send_rx(8'h46, 1'b0);
        chk("R8 idle after identify", busy, 0);
        chk("R8 capacity latched", capacity, capv);
        iden_capacity = 48'h7;
        repeat (4) tick();
        chk("R8 capacity holds", capacity, capv);

        // erase: no timeout
        timeout_limit = 32'd40;
        issue(2'b01, 48'hFFFF, 48'hFFFF);
        wait_check_fis("R1 R5 erase fis", 2'b01, 48'h0, 16'h0);
        repeat (200) tick();
        chk("R11 no timeout during erase", err_vec, 0);
        chk("R11 busy during erase", busy, 1);
        send_rx(8'h34, 1'b0);
        chk("R11 erase done", busy, 0);

        // timer restarts on each FIS
        issue(2'b11, 48'h100, 48'd10);
        wait_check_fis("R10 read fis", 2'b11, 48'h100, 16'd10);
        for (int i = 0; i < 4; i++) begin
            repeat (30) tick();
            send_rx(8'h46, 1'b0);
        end
        chk("R10 restart keeps clear", err_vec, 0);
        send_rx(8'h34, 1'b0);
        chk("R10 read finished", busy, 0);
        timeout_limit = 32'd1000;

        // directed chunk boundaries
        stall_en = 1'b1;
        run_dma(2'b11, 48'h0000_0000_1000, 48'd65536, 1);
        run_dma(2'b10, 48'h0000_00FF_FFF0, 48'd131073, 0);
        run_dma(2'b10, 48'h7FFF_FFFF_FFFF, 48'd1, 0);
        run_dma(2'b11, 48'h0000_0001_0000, 48'd65537, 0);

        // random mix
        for (int n = 0; n < 8; n++) begin
            ra = {16'($urandom % 32768), 32'($urandom)};
            rl = 48'(1 + ($urandom % 200000));
            run_dma(($urandom % 2) ? 2'b11 : 2'b10, ra, rl, (n == 3));
        end
        stall_en = 1'b0;

        // R9: data FIS during write -> bit 1, then halt
        reset_dut();
        issue(2'b10, 48'h20, 48'd4);
        wait_check_fis("R9 write fis", 2'b10, 48'h20, 16'd4);
        send_rx(8'h46, 1'b0);
        chk("R9 data fis unexpected bit1", {err_flag, err_vec}, {1'b1, 32'h2});
        issue(2'b11, 48'h0, 48'd1);
        repeat (6) tick();
        chk("R12 halted sends nothing", ncap, 0);
        chk("R12 halted busy", busy, 1);
        rx_link_err = 1'b1;
        tick();
        rx_link_err = 1'b0;
        send_rx(8'h34, 1'b1);
        chk("R12 vector sticky", err_vec, 32'h2);
        reset_dut();
        chk("R12 reset clears", err_vec, 0);

        // R9: status error in read -> bit 2
        issue(2'b11, 48'h40, 48'd3);
        wait_check_fis("R9 read fis", 2'b11, 48'h40, 16'd3);
        send_rx(8'h34, 1'b1);
        chk("R9 status err bit2", err_vec, 32'h4);

        // R9: wrong FIS during identify -> bit 4
        reset_dut();
        issue(2'b00, 48'h0, 48'h0);
        wait_check_fis("R9 identify fis", 2'b00, 48'h0, 16'h0);
        send_rx(8'h34, 1'b0);
        chk("R9 identify unexpected bit4", err_vec, 32'h10);

        // R9: wrong FIS during write -> bit 3
        reset_dut();
        issue(2'b10, 48'h80, 48'd2);
        wait_check_fis("R9 write fis2", 2'b10, 48'h80, 16'd2);
        send_rx(8'h5F, 1'b0);
        chk("R9 write unexpected bit3", err_vec, 32'h8);

        // R9: link error -> bit 0
        reset_dut();
        rx_link_err = 1'b1;
        tick();
        rx_link_err = 1'b0;
        chk("R9 link err bit0", {err_flag, busy, err_vec}, {1'b1, 1'b1, 32'h1});

        // R10: timeout -> bit 5
        reset_dut();
        timeout_limit = 32'd40;
        issue(2'b11, 48'h9, 48'd5);
        wait_check_fis("R10 timeout fis", 2'b11, 48'h9, 16'd5);
        repeat (20) tick();
        chk("R10 no early timeout", err_vec, 0);
        repeat (30) tick();
        chk("R10 timeout bit5", {err_flag, busy, err_vec}, {1'b1, 1'b1, 32'h20});

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule